// File: doc/BRIEF.md
# Level-Sensitive Interrupt Pending Controller

This block keeps three state bits for each interrupt in a bank of level-sensitive peripheral lines: enable, pending and active. A fourth per-interrupt bit says whether requesters in the non-secure state may touch that interrupt. Software changes enable and pending through word-wide write-one-to-act registers, with 32 interrupts per word. Set and clear are separate registers, so no read-modify-write is needed.

Pending is derived again from the input level on every clock. A high line on an interrupt that is not active keeps it pending, even after a clear-pending write. A separate core-side handshake does two things. An acknowledge carrying an interrupt number marks that interrupt taken. A return strobe carrying an interrupt number marks it finished. The block presents the highest-numbered interrupt that is pending, enabled and not active as its single request.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, every enable, pending, active and non-secure-access bit is 0, `req_o` is low and every readback is 0.
- R2: An interrupt whose line is high while its active bit is 0 reads as pending one cycle later. This holds on every cycle the condition holds, not only on a rising edge.
- R3: A clear-pending write (`wr_sel_i` = 3) is ignored for an interrupt whose line is high and which is not active, so it still reads as pending afterwards.
- R4: A clear-pending write does clear pending when the line is low or the interrupt is active. While an interrupt is active, a high line does not make it pending.
- R5: A set-pending write (`wr_sel_i` = 2) makes the interrupt pending regardless of its line level.
- R6: In a set-enable write (`wr_sel_i` = 0), each 1 bit sets that enable. In a clear-enable write (`wr_sel_i` = 1), each 1 bit clears that enable. Zero bits leave the enable unchanged.
- R7: Data bit b of a write to word w acts on interrupt 32*w+b. A write whose word index is NUM_IRQ/32 or higher changes nothing.
- R8: A bit of a per-interrupt write takes effect only if `wr_secure_i` is 1 or that interrupt's non-secure-access bit is set. The access word (`wr_sel_i` = 4) is replaced by the data on a secure write and is left unchanged by a non-secure write.
- R9: An acknowledge (`ack_valid_i`, `ack_id_i`) clears the pending bit of that interrupt and sets its active bit on the same clock edge.
- R10: A return strobe (`eoi_valid_i`, `eoi_id_i`) clears the active bit. If the line is still high, pending is set one cycle later.
- R11: `req_o` is high exactly when some interrupt is pending, enabled and not active. `req_id_o` is then the highest such index.
- R12: Readback with `rd_sel_i` 0 or 1 returns enable bits, with 2 or 3 returns pending bits, and with 4 returns the access word. For a non-secure read, bits of interrupts without non-secure access read as 0, and the access word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_line_i | input | NUM_IRQ | Level-sensitive interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write register select (0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 access) |
| wr_word_i | input | WIDX_W | Write word index |
| wr_data_i | input | 32 | Write data, one bit per interrupt |
| wr_secure_i | input | 1 | Write issued in the secure state |
| rd_sel_i | input | 3 | Read register select, same encoding as writes |
| rd_word_i | input | WIDX_W | Read word index |
| rd_secure_i | input | 1 | Read issued in the secure state |
| rd_data_o | output | 32 | Read data (combinational) |
| ack_valid_i | input | 1 | Interrupt taken strobe |
| ack_id_i | input | ID_W | Number of the interrupt taken |
| eoi_valid_i | input | 1 | Exception return strobe |
| eoi_id_i | input | ID_W | Number of the interrupt returning |
| req_o | output | 1 | An interrupt qualifies for service |
| req_id_o | output | ID_W | Highest qualifying interrupt number |

## Verification
The main target is a clear-pending write that lands while the line is still high. A design that stores pending as an edge-set flop would drop the request at that point, and its peripheral would never be serviced again. The bench also clears pending during the active window, then sends a return with the line held high. A design that looks at the level during the active window, or one that forgets to re-derive pending after the return, shows a wrong pending readback on one of those exact cycles. Non-secure writes to interrupts without access, writes to word indices beyond the bank, and writes of zero bits must all leave state untouched. Random traffic then mixes acknowledges, returns and all five write targets against a bench model, which catches priority inversions in `req_id_o` and leaks in readback masking.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    SEL_SET_EN = 3'd0,
    SEL_CLR_EN = 3'd1,
    SEL_SET_PD = 3'd2,
    SEL_CLR_PD = 3'd3,
    SEL_ACCESS = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irq_pend_regif.sv
module irq_pend_regif
  import irq_pend_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned WIDX_W  = 4,
  localparam int unsigned NUM_WORDS = NUM_IRQ / WORD_W
) (
  input  logic                 wr_en_i,
  input  logic [2:0]           wr_sel_i,
  input  logic [WIDX_W-1:0]    wr_word_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  input  logic                 wr_secure_i,
  input  logic [NUM_IRQ-1:0]   ns_access_i,
  output logic [NUM_IRQ-1:0]   set_en_o,
  output logic [NUM_IRQ-1:0]   clr_en_o,
  output logic [NUM_IRQ-1:0]   set_pd_o,
  output logic [NUM_IRQ-1:0]   clr_pd_o,
  output logic [NUM_WORDS-1:0] acc_we_o,
  output logic [WORD_W-1:0]    acc_wdata_o
);
  assign acc_wdata_o = wr_data_i;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic word_hit;
    assign word_hit    = wr_en_i && (wr_word_i == WIDX_W'(w));
    assign acc_we_o[w] = word_hit && wr_secure_i && (wr_sel_i == SEL_ACCESS);

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      localparam int unsigned K = w * WORD_W + b;
      logic bit_hit;
      // per-bit security gate
      assign bit_hit     = word_hit && wr_data_i[b] && (wr_secure_i || ns_access_i[K]);
      assign set_en_o[K] = bit_hit && (wr_sel_i == SEL_SET_EN);
      assign clr_en_o[K] = bit_hit && (wr_sel_i == SEL_CLR_EN);
      assign set_pd_o[K] = bit_hit && (wr_sel_i == SEL_SET_PD);
      assign clr_pd_o[K] = bit_hit && (wr_sel_i == SEL_CLR_PD);
    end
  end
endmodule

// File: rtl/irq_pend_state.sv
module irq_pend_state
  import irq_pend_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  localparam int unsigned NUM_WORDS = NUM_IRQ / WORD_W,
  localparam int unsigned ID_W = $clog2(NUM_IRQ)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_IRQ-1:0]   line_i,
  input  logic [NUM_IRQ-1:0]   set_en_i,
  input  logic [NUM_IRQ-1:0]   clr_en_i,
  input  logic [NUM_IRQ-1:0]   set_pd_i,
  input  logic [NUM_IRQ-1:0]   clr_pd_i,
  input  logic [NUM_WORDS-1:0] acc_we_i,
  input  logic [WORD_W-1:0]    acc_wdata_i,
  input  logic                 ack_valid_i,
  input  logic [ID_W-1:0]      ack_id_i,
  input  logic                 eoi_valid_i,
  input  logic [ID_W-1:0]      eoi_id_i,
  output logic [NUM_IRQ-1:0]   en_o,
  output logic [NUM_IRQ-1:0]   pend_o,
  output logic [NUM_IRQ-1:0]   act_o,
  output logic [NUM_IRQ-1:0]   acc_o
);
  logic [NUM_IRQ-1:0] en_q, pend_q, act_q, acc_q;
  logic [NUM_IRQ-1:0] en_d, pend_d, act_d, acc_d;
  logic [NUM_IRQ-1:0] ack_hit, eoi_hit;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_dec
    assign ack_hit[k] = ack_valid_i && (ack_id_i == ID_W'(k));
    assign eoi_hit[k] = eoi_valid_i && (eoi_id_i == ID_W'(k));
  end

  always_comb begin
    for (int k = 0; k < NUM_IRQ; k++) begin
      en_d[k] = set_en_i[k] ? 1'b1 : (clr_en_i[k] ? 1'b0 : en_q[k]);

      if (ack_hit[k])      act_d[k] = 1'b1;
      else if (eoi_hit[k]) act_d[k] = 1'b0;
      else                 act_d[k] = act_q[k];

      // level term outranks a software clear; active blocks it
      if (ack_hit[k])                   pend_d[k] = 1'b0;
      else if (line_i[k] && !act_q[k])  pend_d[k] = 1'b1;
      else if (set_pd_i[k])             pend_d[k] = 1'b1;
      else if (clr_pd_i[k])             pend_d[k] = 1'b0;
      else                              pend_d[k] = pend_q[k];
    end
    for (int w = 0; w < NUM_WORDS; w++) begin
      acc_d[w*WORD_W +: WORD_W] = acc_we_i[w] ? acc_wdata_i : acc_q[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      acc_q  <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      acc_q  <= acc_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign act_o  = act_q;
  assign acc_o  = acc_q;
endmodule

// File: rtl/irq_pend_prio.sv
module irq_pend_prio #(
  parameter int unsigned NUM_IRQ = 64,
  localparam int unsigned ID_W = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] qual_i,
  output logic               valid_o,
  output logic [ID_W-1:0]    id_o
);
  // ascending scan: last hit is the highest index
  always_comb begin
    id_o = '0;
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (qual_i[k]) id_o = ID_W'(k);
    end
  end
  assign valid_o = |qual_i;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned WIDX_W  = 4,
  localparam int unsigned ID_W = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_line_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [WIDX_W-1:0]  wr_word_i,
  input  logic [31:0]        wr_data_i,
  input  logic               wr_secure_i,
  input  logic [2:0]         rd_sel_i,
  input  logic [WIDX_W-1:0]  rd_word_i,
  input  logic               rd_secure_i,
  output logic [31:0]        rd_data_o,
  input  logic               ack_valid_i,
  input  logic [ID_W-1:0]    ack_id_i,
  input  logic               eoi_valid_i,
  input  logic [ID_W-1:0]    eoi_id_i,
  output logic               req_o,
  output logic [ID_W-1:0]    req_id_o
);
  localparam int unsigned NUM_WORDS = NUM_IRQ / WORD_W;

  logic [NUM_IRQ-1:0]   set_en, clr_en, set_pd, clr_pd;
  logic [NUM_WORDS-1:0] acc_we;
  logic [WORD_W-1:0]    acc_wdata;
  logic [NUM_IRQ-1:0]   en_q, pend_q, act_q, acc_q;
  logic [WORD_W-1:0]    rd_vis;

  irq_pend_regif #(.NUM_IRQ(NUM_IRQ), .WIDX_W(WIDX_W)) u_regif (
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_word_i   (wr_word_i),
    .wr_data_i   (wr_data_i),
    .wr_secure_i (wr_secure_i),
    .ns_access_i (acc_q),
    .set_en_o    (set_en),
    .clr_en_o    (clr_en),
    .set_pd_o    (set_pd),
    .clr_pd_o    (clr_pd),
    .acc_we_o    (acc_we),
    .acc_wdata_o (acc_wdata)
  );

  irq_pend_state #(.NUM_IRQ(NUM_IRQ)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_i      (irq_line_i),
    .set_en_i    (set_en),
    .clr_en_i    (clr_en),
    .set_pd_i    (set_pd),
    .clr_pd_i    (clr_pd),
    .acc_we_i    (acc_we),
    .acc_wdata_i (acc_wdata),
    .ack_valid_i (ack_valid_i),
    .ack_id_i    (ack_id_i),
    .eoi_valid_i (eoi_valid_i),
    .eoi_id_i    (eoi_id_i),
    .en_o        (en_q),
    .pend_o      (pend_q),
    .act_o       (act_q),
    .acc_o       (acc_q)
  );

  irq_pend_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
    .qual_i  (pend_q & en_q & ~act_q),
    .valid_o (req_o),
    .id_o    (req_id_o)
  );

  always_comb begin
    rd_data_o = '0;
    rd_vis    = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (rd_word_i == WIDX_W'(w)) begin
        rd_vis = rd_secure_i ? '1 : acc_q[w*WORD_W +: WORD_W];
        case (rd_sel_i)
          SEL_SET_EN, SEL_CLR_EN: rd_data_o = en_q[w*WORD_W +: WORD_W] & rd_vis;
          SEL_SET_PD, SEL_CLR_PD: rd_data_o = pend_q[w*WORD_W +: WORD_W] & rd_vis;
          SEL_ACCESS:             rd_data_o = rd_secure_i ? acc_q[w*WORD_W +: WORD_W] : '0;
          default:                rd_data_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_pend_ctrl_sva.sv
module irq_pend_ctrl_sva #(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned WIDX_W  = 4,
  localparam int unsigned ID_W = $clog2(NUM_IRQ)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_IRQ-1:0] irq_line_i,
  input logic               wr_en_i,
  input logic [2:0]         wr_sel_i,
  input logic [WIDX_W-1:0]  wr_word_i,
  input logic               wr_secure_i,
  input logic               ack_valid_i,
  input logic [ID_W-1:0]    ack_id_i,
  input logic               eoi_valid_i,
  input logic [ID_W-1:0]    eoi_id_i,
  input logic               req_o,
  input logic [ID_W-1:0]    req_id_o,
  input logic [NUM_IRQ-1:0] en_q,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_IRQ-1:0] act_q,
  input logic [NUM_IRQ-1:0] acc_q
);
  assert_req_qual_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (pend_q[req_id_o] && en_q[req_id_o] && !act_q[req_id_o]));

  assert_req_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & en_q & ~act_q) == '0) |-> !req_o);

  assert_ack_take_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_i |=> (act_q[$past(ack_id_i)] && !pend_q[$past(ack_id_i)]));

  assert_eoi_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_valid_i && !(ack_valid_i && ack_id_i == eoi_id_i)) |=> !act_q[$past(eoi_id_i)]);

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    assert_level_pend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_line_i[k] && !act_q[k] && !(ack_valid_i && ack_id_i == ID_W'(k))) |=> pend_q[k]);

    assert_ns_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !wr_secure_i && !acc_q[k] && (wr_word_i == WIDX_W'(k / 32)) &&
       (wr_sel_i == 3'd0 || wr_sel_i == 3'd1)) |=> (en_q[k] == $past(en_q[k])));
  end
endmodule

bind irq_pend_ctrl irq_pend_ctrl_sva #(.NUM_IRQ(NUM_IRQ), .WIDX_W(WIDX_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_line_i  (irq_line_i),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_word_i   (wr_word_i),
  .wr_secure_i (wr_secure_i),
  .ack_valid_i (ack_valid_i),
  .ack_id_i    (ack_id_i),
  .eoi_valid_i (eoi_valid_i),
  .eoi_id_i    (eoi_id_i),
  .req_o       (req_o),
  .req_id_o    (req_id_o),
  .en_q        (en_q),
  .pend_q      (pend_q),
  .act_q       (act_q),
  .acc_q       (acc_q)
);

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb;
  localparam int unsigned N     = 64;
  localparam int unsigned WW    = 4;
  localparam int unsigned IW    = 6;
  localparam int unsigned NW    = N / 32;
  localparam time         CLK_P = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  line = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [WW-1:0] wr_word = '0;
  logic [31:0]   wr_data = '0;
  logic          wr_sec = 1'b0;
  logic [2:0]    rd_sel = '0;
  logic [WW-1:0] rd_word = '0;
  logic          rd_sec = 1'b0;
  logic [31:0]   rd_data;
  logic          ack_v = 1'b0;
  logic [IW-1:0] ack_id = '0;
  logic          eoi_v = 1'b0;
  logic [IW-1:0] eoi_id = '0;
  logic          req;
  logic [IW-1:0] req_id;

  logic [N-1:0] m_en = '0, m_pd = '0, m_act = '0, m_acc = '0;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_pend_ctrl #(.NUM_IRQ(N), .WIDX_W(WW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_line_i(line),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_word_i(wr_word), .wr_data_i(wr_data),
    .wr_secure_i(wr_sec), .rd_sel_i(rd_sel), .rd_word_i(rd_word), .rd_secure_i(rd_sec),
    .rd_data_o(rd_data), .ack_valid_i(ack_v), .ack_id_i(ack_id),
    .eoi_valid_i(eoi_v), .eoi_id_i(eoi_id), .req_o(req), .req_id_o(req_id)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [2:0] sel, input int w, input bit sec);
    logic [31:0] vis;
    if (w >= NW) return '0;
    vis = sec ? '1 : m_acc[w*32 +: 32];
    case (sel)
      3'd0, 3'd1: return m_en[w*32 +: 32] & vis;
      3'd2, 3'd3: return m_pd[w*32 +: 32] & vis;
      3'd4:       return sec ? m_acc[w*32 +: 32] : '0;
      default:    return '0;
    endcase
  endfunction

  function automatic int exp_req_id();
    int id = -1;
    for (int k = 0; k < N; k++) if (m_pd[k] && m_en[k] && !m_act[k]) id = k;
    return id;
  endfunction

  task automatic rd(input logic [2:0] sel, input int w, input bit sec, output logic [31:0] d);
    rd_sel = sel; rd_word = WW'(w); rd_sec = sec;
    #1;
    d = rd_data;
  endtask

  task automatic check_all();
    logic [31:0] d;
    int id = exp_req_id();
    chk(req == (id >= 0), "R11 req_o", 64'(req), 64'(id >= 0));
    if (id >= 0) chk(req_id == IW'(id), "R11 req_id_o", 64'(req_id), 64'(id));
    for (int w = 0; w <= NW; w++)
      for (int s = 0; s < 5; s++)
        for (int sc = 0; sc < 2; sc++) begin
          rd(3'(s), w, sc[0], d);
          chk(d == exp_read(3'(s), w, sc[0]), "R12 readback", 64'(d), 64'(exp_read(3'(s), w, sc[0])));
        end
  endtask

  // model update from inputs driven this cycle, then clock and compare
  task automatic step();
    logic [N-1:0] n_en, n_pd, n_act, n_acc;
    n_en = m_en; n_pd = m_pd; n_act = m_act; n_acc = m_acc;
    for (int k = 0; k < N; k++) begin
      bit hit, ah, eh;
      hit = wr_en && (int'(wr_word) == k / 32) && wr_data[k % 32] && (wr_sec || m_acc[k]);
      ah  = ack_v && (int'(ack_id) == k);
      eh  = eoi_v && (int'(eoi_id) == k);
      if (hit && wr_sel == 3'd0) n_en[k] = 1'b1;
      if (hit && wr_sel == 3'd1) n_en[k] = 1'b0;
      if (ah) n_act[k] = 1'b1; else if (eh) n_act[k] = 1'b0;
      if (ah) n_pd[k] = 1'b0;
      else if (line[k] && !m_act[k]) n_pd[k] = 1'b1;
      else if (hit && wr_sel == 3'd2) n_pd[k] = 1'b1;
      else if (hit && wr_sel == 3'd3) n_pd[k] = 1'b0;
    end
    if (wr_en && wr_sec && wr_sel == 3'd4 && int'(wr_word) < NW)
      n_acc[int'(wr_word)*32 +: 32] = wr_data;
    @(posedge clk);
    m_en = n_en; m_pd = n_pd; m_act = n_act; m_acc = n_acc;
    #1;
    check_all();
    @(negedge clk);
    wr_en = 1'b0; ack_v = 1'b0; eoi_v = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input int w, input logic [31:0] d, input bit sec);
    wr_en = 1'b1; wr_sel = sel; wr_word = WW'(w); wr_data = d; wr_sec = sec;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(req == 1'b0, "R1 req after reset", 64'(req), 64'd0);
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < 5; s++) begin
        rd(3'(s), w, 1'b1, d);
        chk(d == '0, "R1 readback after reset", 64'(d), 64'd0);
      end

    // R6 enable write-one semantics
    wr(3'd0, 0, 32'h5, 1'b1);
    rd(3'd0, 0, 1'b1, d); chk(d == 32'h5, "R6 set-enable", 64'(d), 64'h5);
    wr(3'd0, 0, 32'h0, 1'b1);
    rd(3'd1, 0, 1'b1, d); chk(d == 32'h5, "R6 zero bits no change", 64'(d), 64'h5);
    wr(3'd1, 0, 32'h1, 1'b1);
    rd(3'd0, 0, 1'b1, d); chk(d == 32'h4, "R6 clear-enable", 64'(d), 64'h4);

    // R2 level sets pending
    line = 64'h4;
    step();
    rd(3'd2, 0, 1'b1, d); chk(d == 32'h4, "R2 level pending", 64'(d), 64'h4);
    chk(req && req_id == 6'd2, "R11 req for irq 2", 64'(req_id), 64'd2);

    // R3 clear ignored while line high and inactive
    wr(3'd3, 0, 32'h4, 1'b1);
    rd(3'd3, 0, 1'b1, d); chk(d == 32'h4, "R3 clear overridden", 64'(d), 64'h4);

    // R9 acknowledge
    ack_v = 1'b1; ack_id = 6'd2;
    step();
    rd(3'd2, 0, 1'b1, d); chk(d == 32'h0, "R9 ack clears pending", 64'(d), 64'h0);
    chk(!req, "R9 active masks request", 64'(req), 64'd0);

    // R4 active blocks level
    step();
    rd(3'd2, 0, 1'b1, d); chk(d == 32'h0, "R4 no level pend while active", 64'(d), 64'h0);
    wr(3'd2, 0, 32'h4, 1'b1);
    rd(3'd2, 0, 1'b1, d); chk(d == 32'h4, "R5 set-pending while active", 64'(d), 64'h4);
    wr(3'd3, 0, 32'h4, 1'b1);
    rd(3'd2, 0, 1'b1, d); chk(d == 32'h0, "R4 clear while active", 64'(d), 64'h0);

    // R10 return, line still high
    eoi_v = 1'b1; eoi_id = 6'd2;
    step();
    rd(3'd2, 0, 1'b1, d); chk(d == 32'h0, "R10 not pending on return edge", 64'(d), 64'h0);
    step();
    rd(3'd2, 0, 1'b1, d); chk(d == 32'h4, "R10 pending again after return", 64'(d), 64'h4);

    // R4 clear with line low
    line = '0;
    wr(3'd3, 0, 32'h4, 1'b1);
    rd(3'd2, 0, 1'b1, d); chk(d == 32'h0, "R4 clear with line low", 64'(d), 64'h0);

    // R5 / R7 upper word, R11 highest index
    wr(3'd2, 1, 32'h8000_0000, 1'b1);
    rd(3'd2, 1, 1'b1, d); chk(d == 32'h8000_0000, "R5 set-pending line low", 64'(d), 64'h8000_0000);
    wr(3'd0, 1, 32'h8000_0000, 1'b1);
    chk(req && req_id == 6'd63, "R7 word 1 bit 31 is irq 63", 64'(req_id), 64'd63);
    wr(3'd0, 5, 32'hFFFF_FFFF, 1'b1);
    rd(3'd0, 0, 1'b1, d); chk(d == 32'h4, "R7 out-of-range word ignored", 64'(d), 64'h4);
    rd(3'd0, 1, 1'b1, d); chk(d == 32'h8000_0000, "R7 out-of-range word ignored", 64'(d), 64'h8000_0000);

    // R8 security gating
    wr(3'd0, 0, 32'h2, 1'b0);
    rd(3'd0, 0, 1'b1, d); chk(d == 32'h4, "R8 non-secure dropped", 64'(d), 64'h4);
    wr(3'd4, 0, 32'h2, 1'b1);
    wr(3'd0, 0, 32'h3, 1'b0);
    rd(3'd0, 0, 1'b1, d); chk(d == 32'h6, "R8 non-secure with access", 64'(d), 64'h6);
    rd(3'd0, 0, 1'b0, d); chk(d == 32'h2, "R12 non-secure read masked", 64'(d), 64'h2);
    wr(3'd4, 0, 32'hFFFF_FFFF, 1'b0);
    rd(3'd4, 0, 1'b1, d); chk(d == 32'h2, "R8 access word secure-only", 64'(d), 64'h2);

    // random phase
    for (int it = 0; it < 600; it++) begin
      logic [N-1:0] flip;
      int rid;
      flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      line = line ^ flip;
      wr_en   = ($urandom % 2) == 0;
      wr_sel  = 3'($urandom % 5);
      wr_word = WW'($urandom % (NW + 1));
      wr_data = $urandom;
      wr_sec  = ($urandom % 4) != 0;
      rid = exp_req_id();
      if (rid >= 0 && ($urandom % 3) == 0) begin ack_v = 1'b1; ack_id = IW'(rid); end
      begin
        int e = int'($urandom % N);
        if (m_act[e] && !(ack_v && int'(ack_id) == e) && ($urandom % 3) == 0) begin
          eoi_v = 1'b1; eoi_id = IW'(e);
        end
      end
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule